// File: doc/BRIEF.md
# Six-Step Block Commutation Decoder

This block turns a single PWM stream and a three-bit rotor position code into the six gate enables of a three-phase bridge. The position code may come from a controller or straight from three Hall sensors. An internal six-step table picks, for each code, the phase whose high side carries the PWM (the source) and the phase whose low side is held on (the sink). The third phase is left floating. Two more codes are special: one stops the bridge and one aligns the rotor.

A direction input reverses rotation by complementing the lookup. An active-low brake input overrides everything else and either shorts the windings through the low sides or, if coast is selected, releases all six gates. A configuration bit chooses how the PWM phase freewheels: synchronously, with its low side driven by the inverted PWM, or asynchronously, with that low side held off so current flows through the body diode.

The position, direction, brake and PWM inputs each pass through a two-flop synchronizer. The decoded request is registered. Each phase then has a dead-time stage that delays every rising gate enable by a programmable number of clock cycles, measured from the moment the complementary gate of the same phase is off.

Top module: `sixstep_commutator`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first decode, all six gate outputs are low.
- R2: The position code is `hall_in`, with bit 2 for phase A, bit 1 for phase B and bit 0 for phase C. Code 000 is stop: all six gates are off, whatever the direction.
- R3: Code 111 is align, with the same mapping for both directions. The phase A high side follows PWM, the phase A low side follows the synchronous or asynchronous rule of R7, the phase B and C low sides are on, and the B and C high sides are off.
- R4: With `dir_in`=0 the codes map to source and sink as follows: 100 gives A to C, 101 gives A to B, 001 gives C to B, 011 gives C to A, 010 gives B to A, 110 gives B to C.
- R5: With `dir_in`=1, a commutation code selects the phase pair that its bitwise complement selects under `dir_in`=0. For example, 001 gives B to C.
- R6: In a commutation state, the source high side equals PWM, the sink low side is on, and both gates of the third phase are off.
- R7: With `async_rect`=0, the low side of the PWM phase is the inverse of PWM. With `async_rect`=1 that low side stays off.
- R8: When `brake_n_in` is low and `coast_sel`=0, all high sides are off and all low sides are on, whatever the other inputs are.
- R9: When `brake_n_in` is low and `coast_sel`=1, all six gates are off.
- R10: The high and low outputs of a phase are never on together. A gate rises only after its partner has been off for `dead_cycles` full cycles.
- R11: A change on a synchronized input turns a gate off on the 4th rising clock edge. It turns a gate on at the 4th edge plus `dead_cycles` when the partner was already off, or at the 5th edge plus `dead_cycles` when the partner had to turn off first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | PWM stream |
| hall_in | input | 3 | Position code: bit 2 is A, bit 1 is B, bit 0 is C |
| dir_in | input | 1 | Rotation direction |
| brake_n_in | input | 1 | Active-low brake request |
| async_rect | input | 1 | 1 selects diode freewheeling, 0 selects synchronous freewheeling |
| coast_sel | input | 1 | 1 makes the brake request release all gates |
| dead_cycles | input | DT_W | Dead time in clock cycles |
| gate_hi | output | 3 | High-side enables, bit 0 is A, bit 1 is B, bit 2 is C |
| gate_lo | output | 3 | Low-side enables, same bit order |

## Verification
Inputs pass two synchronizer flops and the decode register, so the gate stage sees a change at the third edge. A gate therefore falls at edge 4. It rises at edge 4 plus the dead time when its partner was already off, and one edge later when the partner first had to fall. The bench checks decode results only once that window has passed, with several spare cycles. The timing cases count edges one by one and sample the cycle before and the cycle of the expected transition.

// File: rtl/sixstep_pkg.sv
package sixstep_pkg;

  typedef enum logic [1:0] {
    PH_A    = 2'd0,
    PH_B    = 2'd1,
    PH_C    = 2'd2,
    PH_NONE = 2'd3
  } phase_e;

  typedef struct packed {
    logic [2:0] lo;
    logic [2:0] hi;
  } gate_vec_t;

  localparam logic [2:0] CODE_STOP  = 3'b000;
  localparam logic [2:0] CODE_ALIGN = 3'b111;

  // The phase that carries PWM for a direction-0 code.
  function automatic phase_e source_of(input logic [2:0] code);
    case (code)
      3'b100, 3'b101: source_of = PH_A;
      3'b010, 3'b110: source_of = PH_B;
      3'b001, 3'b011: source_of = PH_C;
      default:        source_of = PH_NONE;
    endcase
  endfunction

  // The phase whose low side is held on for a direction-0 code.
  function automatic phase_e sink_of(input logic [2:0] code);
    case (code)
      3'b011, 3'b010: sink_of = PH_A;
      3'b101, 3'b001: sink_of = PH_B;
      3'b110, 3'b100: sink_of = PH_C;
      default:        sink_of = PH_NONE;
    endcase
  endfunction

  // Direction 1 complements commutation codes but keeps stop and align.
  function automatic logic [2:0] oriented_code(input logic [2:0] code,
                                               input logic       dir);
    if (dir && code != CODE_STOP && code != CODE_ALIGN)
      oriented_code = ~code;
    else
      oriented_code = code;
  endfunction

  function automatic gate_vec_t decode_gates(input logic [2:0] code,
                                             input logic       dir,
                                             input logic       pwm,
                                             input logic       diode_fw,
                                             input logic       brake_req,
                                             input logic       coast);
    gate_vec_t  v;
    logic [2:0] eff;
    phase_e     src;
    phase_e     snk;
    logic       fw_lo;
    v     = '0;
    eff   = oriented_code(code, dir);
    src   = source_of(eff);
    snk   = sink_of(eff);
    fw_lo = diode_fw ? 1'b0 : ~pwm;
    if (brake_req) begin
      if (!coast) v.lo = 3'b111;
    end else if (eff == CODE_ALIGN) begin
      v.hi = {2'b00, pwm};
      v.lo = {2'b11, fw_lo};
    end else if (src != PH_NONE && snk != PH_NONE) begin
      v.hi[src] = pwm;
      v.lo[src] = fw_lo;
      v.lo[snk] = 1'b1;
    end
    decode_gates = v;
  endfunction

endpackage

// File: rtl/sixstep_sync.sv
module sixstep_sync #(
  parameter int                 WIDTH     = 6,
  parameter int                 STAGES    = 2,
  parameter logic [WIDTH-1:0]   RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= RESET_VAL;
        else        stage_q[0] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RESET_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/sixstep_decode.sv
module sixstep_decode
  import sixstep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] code,
  input  logic       dir,
  input  logic       pwm,
  input  logic       diode_fw,
  input  logic       brake_req,
  input  logic       coast,
  output gate_vec_t  req
);
  gate_vec_t next_req;

  always_comb next_req = decode_gates(code, dir, pwm, diode_fw, brake_req, coast);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= '0;
    else        req <= next_req;
  end
endmodule

// File: rtl/sixstep_deadtime.sv
module sixstep_deadtime #(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_hi,
  input  logic            req_lo,
  input  logic [DT_W-1:0] dead_cycles,
  output logic            out_hi,
  output logic            out_lo
);
  logic [1:0] req_pair;
  logic [1:0] out_pair;

  assign req_pair = {req_lo, req_hi};
  assign out_hi   = out_pair[0];
  assign out_lo   = out_pair[1];

  for (genvar g = 0; g < 2; g++) begin : g_gate
    logic [DT_W-1:0] wait_cnt;
    logic            partner_on;
    assign partner_on = out_pair[1-g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_pair[g] <= 1'b0;
        wait_cnt    <= '0;
      end else if (!req_pair[g]) begin
        out_pair[g] <= 1'b0;
        wait_cnt    <= '0;
      end else if (out_pair[g]) begin
        out_pair[g] <= 1'b1;
      end else if (partner_on) begin
        wait_cnt    <= '0;
      end else if (wait_cnt >= dead_cycles) begin
        out_pair[g] <= 1'b1;
      end else begin
        wait_cnt    <= wait_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sixstep_commutator.sv
module sixstep_commutator
  import sixstep_pkg::*;
#(
  parameter int DT_W      = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwm_in,
  input  logic [2:0]      hall_in,
  input  logic            dir_in,
  input  logic            brake_n_in,
  input  logic            async_rect,
  input  logic            coast_sel,
  input  logic [DT_W-1:0] dead_cycles,
  output logic [2:0]      gate_hi,
  output logic [2:0]      gate_lo
);
  localparam int SYNC_W = 6;
  localparam logic [SYNC_W-1:0] SYNC_RST = 6'b010000;

  logic [SYNC_W-1:0] sync_q;
  logic [2:0]        code_s;
  logic              dir_s;
  logic              pwm_s;
  logic              brake_n_s;
  logic              brake_req_s;
  gate_vec_t         req;

  sixstep_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_DEPTH), .RESET_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({pwm_in, brake_n_in, dir_in, hall_in}),
    .q_out (sync_q)
  );

  assign code_s      = sync_q[2:0];
  assign dir_s       = sync_q[3];
  assign brake_n_s   = sync_q[4];
  assign pwm_s       = sync_q[5];
  assign brake_req_s = ~brake_n_s;

  sixstep_decode u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .code      (code_s),
    .dir       (dir_s),
    .pwm       (pwm_s),
    .diode_fw  (async_rect),
    .brake_req (brake_req_s),
    .coast     (coast_sel),
    .req       (req)
  );

  for (genvar p = 0; p < 3; p++) begin : g_phase
    sixstep_deadtime #(.DT_W(DT_W)) u_dt (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_hi      (req.hi[p]),
      .req_lo      (req.lo[p]),
      .dead_cycles (dead_cycles),
      .out_hi      (gate_hi[p]),
      .out_lo      (gate_lo[p])
    );
  end
endmodule

// File: rtl/sixstep_checker.sv
module sixstep_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] code_s,
  input logic       brake_req_s,
  input logic       coast_sel,
  input logic [2:0] req_hi,
  input logic [2:0] req_lo,
  input logic [2:0] gate_hi,
  input logic [2:0] gate_lo
);
  for (genvar p = 0; p < 3; p++) begin : g_ph
    assert_no_shoot_through_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi[p] && gate_lo[p]));
    assert_hi_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hi[p]) |-> ($past(req_hi[p]) && !$past(gate_lo[p])));
    assert_lo_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_lo[p]) |-> ($past(req_lo[p]) && !$past(gate_hi[p])));
  end

  assert_brake_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (brake_req_s && !coast_sel) |=> (req_hi == 3'b000 && req_lo == 3'b111));

  assert_coast_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (brake_req_s && coast_sel) |=> (req_hi == 3'b000 && req_lo == 3'b000));

  assert_stop_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!brake_req_s && code_s == 3'b000) |=> (req_hi == 3'b000 && req_lo == 3'b000));
endmodule

bind sixstep_commutator sixstep_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .code_s      (code_s),
  .brake_req_s (brake_req_s),
  .coast_sel   (coast_sel),
  .req_hi      (req.hi),
  .req_lo      (req.lo),
  .gate_hi     (gate_hi),
  .gate_lo     (gate_lo)
);

// File: tb/sixstep_commutator_bench.sv
module sixstep_commutator_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       pwm_in = 1'b0;
  logic [2:0] hall_in = 3'b000;
  logic       dir_in = 1'b0;
  logic       brake_n_in = 1'b1;
  logic       async_rect = 1'b0;
  logic       coast_sel = 1'b0;
  logic [3:0] dead_cycles = 4'd2;
  logic [2:0] gate_hi;
  logic [2:0] gate_lo;
  int         n_tests = 0;
  int         n_fail  = 0;
  bit         done    = 1'b0;

  always #5 clk = ~clk;

  sixstep_commutator u_sixstep_commutator (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .hall_in(hall_in), .dir_in(dir_in),
    .brake_n_in(brake_n_in), .async_rect(async_rect), .coast_sel(coast_sel),
    .dead_cycles(dead_cycles), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  // Expected {lo, hi}, phase A in bit 0, from the requirement tables.
  function automatic logic [5:0] expected(input logic [2:0] code, input logic dir,
                                          input logic pwm, input logic asy,
                                          input logic brk_n, input logic coast);
    logic [2:0] codes [6];
    int         srcs  [6];
    int         snks  [6];
    logic [2:0] hi, lo, look;
    codes = '{3'b100, 3'b101, 3'b001, 3'b011, 3'b010, 3'b110};
    srcs  = '{0, 0, 2, 2, 1, 1};
    snks  = '{2, 1, 1, 0, 0, 2};
    hi = 3'b000; lo = 3'b000;
    look = dir ? (code ^ 3'b111) : code;
    if (!brk_n) begin
      if (!coast) lo = 3'b111;
    end else if (code == 3'b111) begin
      hi[0] = pwm; lo = 3'b110; lo[0] = !asy && !pwm;
    end else if (code != 3'b000) begin
      for (int k = 0; k < 6; k++) if (codes[k] == look) begin
        hi[srcs[k]] = pwm;
        lo[srcs[k]] = !asy && !pwm;
        lo[snks[k]] = 1'b1;
      end
    end
    return {lo, hi};
  endfunction

  task automatic check(input string tag, input logic [5:0] got, input logic [5:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got lo/hi=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic drive(input logic [2:0] c, input logic d, input logic p,
                       input logic a, input logic b, input logic co);
    @(negedge clk);
    hall_in = c; dir_in = d; pwm_in = p; async_rect = a; brake_n_in = b; coast_sel = co;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    hall_in = 3'b101; pwm_in = 1'b1;
    edges(3);
    check("R1 during reset", {gate_lo, gate_hi}, 6'b0);
    @(negedge clk) rst_n = 1'b1;
    edges(2);
    check("R1 before first decode", {gate_lo, gate_hi}, 6'b0);

    // Sweep all codes, directions, PWM levels and freewheel modes.
    for (int a = 0; a < 2; a++)
      for (int d = 0; d < 2; d++)
        for (int p = 0; p < 2; p++)
          for (int c = 0; c < 8; c++) begin
            drive(3'(c), 1'(d), 1'(p), 1'(a), 1'b1, 1'b0);
            edges(10);
            check($sformatf("R2 R3 R4 R5 R6 R7 code=%0d dir=%0d pwm=%0d async=%0d", c, d, p, a),
                  {gate_lo, gate_hi}, expected(3'(c), 1'(d), 1'(p), 1'(a), 1'b1, 1'b0));
          end

    // Brake and coast override every other input.
    for (int co = 0; co < 2; co++)
      for (int c = 0; c < 8; c += 3) begin
        drive(3'(c), 1'(c & 1), 1'b1, 1'b0, 1'b0, 1'(co));
        edges(10);
        check($sformatf("%s code=%0d", co ? "R9 coast" : "R8 brake", c),
              {gate_lo, gate_hi}, expected(3'(c), 1'(c & 1), 1'b1, 1'b0, 1'b0, 1'(co)));
      end

    // R11 timing with dead time 3: rise from stop, partner already off.
    dead_cycles = 4'd3;
    drive(3'b000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    edges(10);
    drive(3'b100, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    edges(6);
    check("R11 A high not yet on at edge 6", {5'b0, gate_hi[0]}, 6'b0);
    edges(1);
    check("R11 A high on at edge 7", {5'b0, gate_hi[0]}, 6'b1);
    edges(5);
    // Brake entry: high side off at edge 4, low side on at edge 8.
    drive(3'b100, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    edges(3);
    check("R11 A high still on at edge 3", {5'b0, gate_hi[0]}, 6'b1);
    edges(1);
    check("R11 A high off at edge 4", {5'b0, gate_hi[0]}, 6'b0);
    edges(3);
    check("R10 A low held by dead time at edge 7", {5'b0, gate_lo[0]}, 6'b0);
    edges(1);
    check("R10 A low on at edge 8", {5'b0, gate_lo[0]}, 6'b1);

    // R11 with zero dead time.
    dead_cycles = 4'd0;
    drive(3'b000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    edges(10);
    drive(3'b100, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    edges(3);
    check("R11 zero dead time, off at edge 3", {5'b0, gate_hi[0]}, 6'b0);
    edges(1);
    check("R11 zero dead time, on at edge 4", {5'b0, gate_hi[0]}, 6'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule